// File: doc/BRIEF.md
# Indexed Colour Palette RAM Port

This block holds a colour lookup table with a red, a green and a blue component for each pixel index. A host reaches it through a byte-wide register port of the auto-incrementing kind. One register sets where a load begins. Another sets where a readback begins. A shared data register moves one colour component per access. A hidden modulo-3 counter selects red, then green, then blue. After each full triplet the entry index steps by one and wraps to zero after the last entry. The load sequence and the readback sequence each keep their own index and their own component counter.

On the display side, a pixel port takes an index and ANDs it with a host-programmable mask. One clock later it returns the three stored components. Only the low bits of each component are kept, and they sit at the bottom of the data byte. The table has one read path, which both sides share. The pixel side has priority on it. A host data read that meets a pixel request waits, and its result appears once the read path is free.

Top module: `pal_lut_port`

## Requirements
- R1: A host write to the load-index register (host_sel = 2) sets the load entry to the written value and restarts the load component counter at red.
- R2: Successive host writes to the data register (host_sel = 1) store red, green and blue of the current load entry, in that order. The load entry increments by one after blue.
- R3: After 256 complete triplets starting from entry 0, the load index wraps to 0 and a read of the load-index register returns 0x00.
- R4: A host write to the readback-index register (host_sel = 3) sets the readback entry and restarts its component counter at red. Data-register reads then return red, green and blue in turn, with the same auto-increment. This sequence is independent of the load sequence.
- R5: Only data bits 5:0 of a component are stored. Bits 7:6 of a data-register read are always 0.
- R6: A pixel request returns, on the next cycle with pix_valid high, the components of the entry at pix_index AND mask.
- R7: The mask register (host_sel = 0) resets to 0xFF, which leaves the index unchanged. It reads back what was last written.
- R8: A host data read in a cycle that has a pixel request is deferred. host_rvalid rises one cycle after the first cycle without a pixel request, and the readback counter does not advance before then.
- R9: A host read of the mask or either index register returns its value with host_rvalid one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | Register select: 0 mask, 1 data, 2 load index, 3 readback index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rvalid | output | 1 | Host read data valid |
| pix_req | input | 1 | Pixel lookup request |
| pix_index | input | 8 | Pixel index before masking |
| pix_valid | output | 1 | Pixel components valid |
| pix_red | output | 6 | Red component |
| pix_green | output | 6 | Green component |
| pix_blue | output | 6 | Blue component |

## Verification
The bench builds the block with its default parameters: an 8-bit index, so 256 entries, and 6-bit components. A full load of 768 data writes and a full readback of 768 data reads are therefore affordable. Both sweeps reach the wrap of the index from 255 to 0 in both sequences. Every entry is looked up through the pixel port with an open mask, and then with a narrowing mask. The bench also runs a collision between a pixel request and a host data read that lasts two cycles, and a load that starts in the middle of the table.

// File: rtl/pal_lut_pkg.sv
package pal_lut_pkg;
   typedef enum logic [1:0] {
      SEL_MASK = 2'd0,
      SEL_DATA = 2'd1,
      SEL_WIDX = 2'd2,
      SEL_RIDX = 2'd3
   } host_sel_e;

   typedef enum logic [1:0] {
      COMP_RED   = 2'd0,
      COMP_GREEN = 2'd1,
      COMP_BLUE  = 2'd2
   } comp_e;

   localparam int NUM_COMP = 3;
endpackage

// File: rtl/pal_step_seq.sv
module pal_step_seq
   import pal_lut_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] load_idx,
   input  logic             step,
   output logic [IDX_W-1:0] idx,
   output comp_e            comp
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx  <= '0;
         comp <= COMP_RED;
      end else if (load) begin
         idx  <= load_idx;
         comp <= COMP_RED;
      end else if (step) begin
         unique case (comp)
            COMP_RED:   comp <= COMP_GREEN;
            COMP_GREEN: comp <= COMP_BLUE;
            default: begin
               comp <= COMP_RED;
               idx  <= idx + 1'b1;
            end
         endcase
      end
   end

   // R1 / R4: loading restarts at red
   assert_load_red_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (comp == COMP_RED) && (idx == $past(load_idx)));
   // R2: blue step advances the entry
   assert_tri_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && comp == COMP_BLUE) |=>
         (comp == COMP_RED) && (idx == IDX_W'($past(idx) + 1'b1)));
   assert_mid_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && comp != COMP_BLUE) |=> $stable(idx) && (comp != COMP_RED));
endmodule

// File: rtl/pal_triplet_store.sv
module pal_triplet_store
   import pal_lut_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 6
) (
   input  logic                             clk,
   input  logic                             wr_en,
   input  logic [IDX_W-1:0]                 wr_idx,
   input  comp_e                            wr_comp,
   input  logic [COMP_W-1:0]                wr_val,
   input  logic [IDX_W-1:0]                 rd_idx,
   output logic [NUM_COMP-1:0][COMP_W-1:0]  rd_trip
);
   localparam int ENTRIES = 1 << IDX_W;

   for (genvar c = 0; c < NUM_COMP; c++) begin : g_lane
      logic [COMP_W-1:0] lane_mem [ENTRIES];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_comp == comp_e'(c)))
            lane_mem[wr_idx] <= wr_val;
      end
      assign rd_trip[c] = lane_mem[rd_idx];
   end
endmodule

// File: rtl/pal_lut_port.sv
module pal_lut_port
   import pal_lut_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [1:0]        host_sel,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rvalid,
   input  logic              pix_req,
   input  logic [IDX_W-1:0]  pix_index,
   output logic              pix_valid,
   output logic [COMP_W-1:0] pix_red,
   output logic [COMP_W-1:0] pix_green,
   output logic [COMP_W-1:0] pix_blue
);
   localparam int PAD_W = DATA_W - COMP_W;

   if (COMP_W > DATA_W) begin : g_bad_comp
      $error("COMP_W must not exceed DATA_W");
   end
   if (IDX_W > DATA_W) begin : g_bad_idx
      $error("IDX_W must not exceed DATA_W");
   end
   if (COMP_W < 1 || IDX_W < 1) begin : g_bad_min
      $error("widths must be positive");
   end

   host_sel_e sel;
   assign sel = host_sel_e'(host_sel);

   logic [IDX_W-1:0] mask_q, widx, ridx, rd_idx;
   comp_e            wcomp, rcomp;
   logic             rd_wait, data_rd_eff, grant;
   logic [NUM_COMP-1:0][COMP_W-1:0] trip;

   assign data_rd_eff = (host_rd && sel == SEL_DATA) || rd_wait;
   assign grant       = data_rd_eff && !pix_req;
   assign rd_idx      = pix_req ? (pix_index & mask_q) : ridx;

   pal_step_seq #(.IDX_W(IDX_W)) i_wseq (
      .clk(clk), .rst_n(rst_n),
      .load(host_wr && sel == SEL_WIDX), .load_idx(host_wdata[IDX_W-1:0]),
      .step(host_wr && sel == SEL_DATA), .idx(widx), .comp(wcomp));

   pal_step_seq #(.IDX_W(IDX_W)) i_rseq (
      .clk(clk), .rst_n(rst_n),
      .load(host_wr && sel == SEL_RIDX), .load_idx(host_wdata[IDX_W-1:0]),
      .step(grant), .idx(ridx), .comp(rcomp));

   pal_triplet_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) i_store (
      .clk(clk), .wr_en(host_wr && sel == SEL_DATA), .wr_idx(widx),
      .wr_comp(wcomp), .wr_val(host_wdata[COMP_W-1:0]),
      .rd_idx(rd_idx), .rd_trip(trip));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q      <= '1;
         rd_wait     <= 1'b0;
         host_rvalid <= 1'b0;
         host_rdata  <= '0;
         pix_valid   <= 1'b0;
         pix_red     <= '0;
         pix_green   <= '0;
         pix_blue    <= '0;
      end else begin
         if (host_wr && sel == SEL_MASK)
            mask_q <= host_wdata[IDX_W-1:0];
         rd_wait     <= data_rd_eff && pix_req;
         host_rvalid <= grant || (host_rd && sel != SEL_DATA);
         if (grant)
            host_rdata <= {{PAD_W{1'b0}}, trip[rcomp]};
         else if (host_rd) begin
            unique case (sel)
               SEL_MASK: host_rdata <= DATA_W'(mask_q);
               SEL_WIDX: host_rdata <= DATA_W'(widx);
               SEL_RIDX: host_rdata <= DATA_W'(ridx);
               default:  host_rdata <= host_rdata;
            endcase
         end
         pix_valid <= pix_req;
         if (pix_req) begin
            pix_red   <= trip[COMP_RED];
            pix_green <= trip[COMP_GREEN];
            pix_blue  <= trip[COMP_BLUE];
         end
      end
   end

   assert_pix_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pix_req |=> pix_valid);
   assert_pix_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_req && data_rd_eff) |=> !host_rvalid && rd_wait);
   assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> host_rdata[DATA_W-1:COMP_W] == '0);
   assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_wait |-> !host_rd);
endmodule

// File: tb/test_pal_lut_port.sv
module test_pal_lut_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic [1:0] host_sel = 2'd0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic       host_rvalid;
   logic       pix_req = 1'b0;
   logic [7:0] pix_index = 8'd0;
   logic       pix_valid;
   logic [5:0] pix_red, pix_green, pix_blue;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pal_lut_port i_pal_lut_port (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_rvalid(host_rvalid), .pix_req(pix_req), .pix_index(pix_index),
      .pix_valid(pix_valid), .pix_red(pix_red), .pix_green(pix_green),
      .pix_blue(pix_blue));

   function automatic int exp_comp(int i, int c);
      case (c)
         0:       return (i * 5 + 3) % 64;
         1:       return (i * 7 + 11) % 64;
         default: return (255 - i) % 64;
      endcase
   endfunction

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic hw(int sel, int data);
      @(negedge clk);
      host_wr = 1'b1; host_sel = 2'(sel); host_wdata = 8'(data);
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hr(int sel, output int val, output int vld);
      @(negedge clk);
      host_rd = 1'b1; host_sel = 2'(sel);
      @(negedge clk);
      host_rd = 1'b0;
      val = host_rdata; vld = host_rvalid;
   endtask

   task automatic px(int idx, output int r, output int g, output int b, output int v);
      @(negedge clk);
      pix_req = 1'b1; pix_index = 8'(idx);
      @(negedge clk);
      pix_req = 1'b0;
      r = pix_red; g = pix_green; b = pix_blue; v = pix_valid;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int v, vl, r, g, b, pv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state (R7, R9)
      chk("reset pix_valid", pix_valid, 0);
      chk("reset host_rvalid", host_rvalid, 0);
      hr(0, v, vl); chk("R7 reset mask", v, 255); chk("R9 rvalid mask", vl, 1);
      hr(2, v, vl); chk("R9 reset load index", v, 0); chk("R9 rvalid", vl, 1);
      // full load with upper bits set (R1, R2, R5)
      hw(2, 0);
      for (int i = 0; i < 256; i++) begin
         for (int c = 0; c < 3; c++) hw(1, 8'hC0 | exp_comp(i, c));
         if (i == 9) begin
            hr(2, v, vl); chk("R2 index after ten triplets", v, 10);
         end
      end
      hr(2, v, vl); chk("R3 load index wrapped", v, 0);
      // full readback (R4, R5)
      hw(3, 0);
      for (int i = 0; i < 256; i++) begin
         for (int c = 0; c < 3; c++) begin
            hr(1, v, vl);
            chk("R4 rvalid data", vl, 1);
            chk("R4 readback component", v & 63, exp_comp(i, c));
            chk("R5 upper bits zero", v >> 6, 0);
         end
      end
      hr(3, v, vl); chk("R4 readback index wrapped", v, 0);
      // pixel sweep with open mask (R6)
      for (int i = 0; i < 256; i++) begin
         px(i, r, g, b, pv);
         chk("R6 pix_valid", pv, 1);
         chk("R6 red", r, exp_comp(i, 0));
         chk("R6 green", g, exp_comp(i, 1));
         chk("R6 blue", b, exp_comp(i, 2));
      end
      // mask (R7, R6)
      hw(0, 8'h0F);
      hr(0, v, vl); chk("R7 mask readback", v, 15);
      for (int i = 0; i < 256; i += 37) begin
         px(i, r, g, b, pv);
         chk("R6 masked red", r, exp_comp(i & 15, 0));
         chk("R6 masked blue", b, exp_comp(i & 15, 2));
      end
      hw(0, 8'hFF);
      // mid-table load and partial triplet (R1, R2)
      hw(2, 250);
      hw(1, 1); hw(1, 2);
      hr(2, v, vl); chk("R2 index held mid triplet", v, 250);
      hw(2, 250);  // restart at red
      hw(1, 40); hw(1, 41); hw(1, 42);
      hr(2, v, vl); chk("R1 index after restart", v, 251);
      px(250, r, g, b, pv);
      chk("R1 restart red", r, 40); chk("R1 green", g, 41); chk("R1 blue", b, 42);
      // load writes do not disturb readback sequence (R4)
      hw(3, 250);
      hr(1, v, vl); chk("R4 red of 250", v, 40);
      hw(2, 7); hw(1, 9);
      hr(1, v, vl); chk("R4 green independent", v, 41);
      hr(3, v, vl); chk("R4 readback index", v, 250);
      // collision with two pixel cycles (R8)
      @(negedge clk);
      pix_req = 1'b1; pix_index = 8'd3; host_rd = 1'b1; host_sel = 2'd1;
      @(negedge clk);
      host_rd = 1'b0;
      chk("R8 deferred cycle 1", host_rvalid, 0);
      chk("R8 pixel served", pix_blue, exp_comp(3, 2));
      @(negedge clk);
      pix_req = 1'b0;
      chk("R8 deferred cycle 2", host_rvalid, 0);
      @(negedge clk);
      chk("R8 rvalid after release", host_rvalid, 1);
      chk("R8 data blue of 250", host_rdata, 42);
      @(negedge clk);
      chk("R8 single pulse", host_rvalid, 0);
      hr(3, v, vl); chk("R8 readback index advanced once", v, 251);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule